// File: doc/BRIEF.md
# Blind Adaptive Complex Equalizer (Constant-Modulus / Per-Axis Modulus)

This block is a streaming complex FIR equalizer that adapts its own weights without a training sequence. Each accepted input sample is first scaled down by a power of two. It is then pushed into a 21-entry delay line and filtered with the current weights. From the filter output a blind error term is formed, and every weight is then updated in one parallel step. A mode pin selects between two error rules. The first is the constant-modulus rule, which works on the whole complex magnitude. The second is the per-axis modulus rule, which treats the real and imaginary parts independently. All arithmetic is 16-bit signed fixed point with 13 fractional bits, and every result saturates instead of wrapping.

The input and output are valid/ready streams. The input side (`s_*`) accepts one sample per transfer, and only while `s_ready` is high. `s_ready` goes low after a transfer and stays low until the result of that sample has been taken. The output side (`m_*`) raises `m_valid` once the weight update for that sample is complete. It then holds the value steady for as long as `m_ready` stays low. The configuration pins are plain levels, and their values are captured only at the moment a sample is accepted. `soft_clr` is a synchronous clear that returns the block to its just-reset state.

Top module: `modulus_equalizer`

## Requirements
- R1: `s_ready` is high only when the block is idle. After a transfer (`s_valid && s_ready` at a clock edge) `s_ready` stays low until exactly one output has been delivered (`m_valid && m_ready`). `s_ready` and `m_valid` are never high together. After reset, `s_ready`=1 and `m_valid`=0.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_re` and `m_im` stay unchanged.
- R3: After reset the delay line is all zero. The weight at index 10 is 1.0 (8192) + 0j, and all other weights are 0. With step size 0, the output for the n-th sample after reset is 0 for n<10 and the scaled input of sample n-10 from then on.
- R4: Values are Q3.13 two's complement (16 bits, range -32768..32767). Every sum, difference, product and shifted result is clamped to these limits.
- R5: The filter output is y = sat((Σk x[k]·w[k]) >>> 13). The complex product is taken as (xr·wr − xi·wi) + j(xr·wi + xi·wr), summed at full width before the shift. Delay-line index 0 holds the newest scaled sample.
- R6: The scaled sample is input >>> `cfg_shift` (arithmetic shift by 0..3, i.e. division by 1, 2, 4 or 8 with rounding toward minus infinity). The output is given in this scaled form.
- R7: With `cfg_mode`=0 (constant modulus): p = sat((yr²+yi²)>>>13), d = sat(p − `cfg_disp`), er = sat((yr·d)>>>13), ei = sat((yi·d)>>>13).
- R8: With `cfg_mode`=1 (per-axis): dr = sat(sat(yr²>>>13) − `cfg_disp`), er = sat((yr·dr)>>>13). The imaginary part is formed the same way from yi.
- R9: g = sat((`cfg_step`·e + 4096) >>> 13) per part (rounded). For every tap k the update is w[k] ← sat(w[k] − sat((g·conj(x[k]))>>>13)), with each part of the product computed at full width. All taps are updated in the same step, after the output and error for this sample.
- R10: `cfg_mode`, `cfg_disp`, `cfg_step` and `cfg_shift` are sampled at the accepting edge. Changes made while a sample is in flight have no effect on that sample's result.
- R11: `soft_clr` high at a clock edge restores the R3 state, drops any pending output and leaves the block idle (`s_ready`=1, `m_valid`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of weights, delay line and handshake state |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_re | input | 16 | Input real part, Q3.13 |
| s_im | input | 16 | Input imaginary part, Q3.13 |
| m_valid | output | 1 | Equalized output valid |
| m_ready | input | 1 | Downstream takes the output |
| m_re | output | 16 | Output real part, scaled Q3.13 |
| m_im | output | 16 | Output imaginary part, scaled Q3.13 |
| cfg_mode | input | 1 | 0 = constant-modulus error, 1 = per-axis error |
| cfg_disp | input | 16 | Dispersion constant, Q3.13 |
| cfg_step | input | 16 | Step size, Q3.13 |
| cfg_shift | input | 2 | Input down-scale exponent (0..3) |

## Verification
With step size zero, a ramp is sent at each of the four shift settings. This separates the delay-line order, the center-tap position and the scaling from any adaptation. Pseudo-random 16-point constellations with a nonzero step are then run in each error mode, and every output is compared bit for bit with an arithmetic model. Because the weights feed back into later outputs, a wrong error rule, rounding step or conjugate sign shows up within a few samples. Full-scale inputs with a large step drive every saturation point. A configuration flip while a sample is in flight, an output stall and a clear while an output is pending each check one rule of the handshake.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int DW = 16;
  localparam int FW = 13;
  localparam int XW = 48;

  typedef logic signed [DW-1:0] smp_t;
  typedef struct packed {
    smp_t re;
    smp_t im;
  } cplx_t;

  typedef enum logic [2:0] {ST_IDLE, ST_FILT, ST_ERR, ST_UPD, ST_OUT} eq_state_t;

  localparam smp_t SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam smp_t SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam smp_t ONE  = {{(DW-FW-1){1'b0}}, 1'b1, {FW{1'b0}}};

  function automatic logic signed [XW-1:0] ext(input smp_t a);
    return XW'(a);
  endfunction

  function automatic smp_t sat(input logic signed [XW-1:0] v);
    if ((&v[XW-1:DW-1]) || !(|v[XW-1:DW-1])) return v[DW-1:0];
    return v[XW-1] ? SMIN : SMAX;
  endfunction

  function automatic smp_t mulq(input smp_t a, input smp_t b);
    logic signed [XW-1:0] p;
    p = ext(a) * ext(b);
    return sat(p >>> FW);
  endfunction

  function automatic smp_t subq(input smp_t a, input smp_t b);
    return sat(ext(a) - ext(b));
  endfunction
endpackage

// File: rtl/eq_filter.sv
module eq_filter import eq_pkg::*; #(
  parameter int NTAPS = 21
) (
  input  cplx_t [NTAPS-1:0] x,
  input  cplx_t [NTAPS-1:0] w,
  output cplx_t             y
);
  logic signed [XW-1:0] acc_re, acc_im;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc_re = acc_re + ext(x[k].re) * ext(w[k].re) - ext(x[k].im) * ext(w[k].im);
      acc_im = acc_im + ext(x[k].re) * ext(w[k].im) + ext(x[k].im) * ext(w[k].re);
    end
    y.re = sat(acc_re >>> FW);
    y.im = sat(acc_im >>> FW);
  end
endmodule

// File: rtl/eq_err.sv
module eq_err import eq_pkg::*; (
  input  logic  per_axis,
  input  smp_t  disp,
  input  cplx_t y,
  output cplx_t e
);
  logic signed [XW-1:0] pw;
  smp_t p_all, d_all, d_re, d_im;

  always_comb begin
    pw    = ext(y.re) * ext(y.re) + ext(y.im) * ext(y.im);
    p_all = sat(pw >>> FW);
    d_all = subq(p_all, disp);
    d_re  = subq(mulq(y.re, y.re), disp);
    d_im  = subq(mulq(y.im, y.im), disp);
    if (per_axis) begin
      e.re = mulq(y.re, d_re);
      e.im = mulq(y.im, d_im);
    end else begin
      e.re = mulq(y.re, d_all);
      e.im = mulq(y.im, d_all);
    end
  end
endmodule

// File: rtl/eq_tap_upd.sv
module eq_tap_upd import eq_pkg::*; (
  input  cplx_t g,
  input  cplx_t x,
  input  cplx_t w,
  output cplx_t w_nx
);
  logic signed [XW-1:0] pr, pi;
  smp_t dr, di;

  always_comb begin
    pr = ext(g.re) * ext(x.re) + ext(g.im) * ext(x.im);
    pi = ext(g.im) * ext(x.re) - ext(g.re) * ext(x.im);
    dr = sat(pr >>> FW);
    di = sat(pi >>> FW);
    w_nx.re = subq(w.re, dr);
    w_nx.im = subq(w.im, di);
  end
endmodule

// File: rtl/modulus_equalizer.sv
module modulus_equalizer import eq_pkg::*; #(
  parameter int NTAPS = 21,
  parameter int SHW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_clr,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_re,
  input  logic signed [DW-1:0] s_im,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_re,
  output logic signed [DW-1:0] m_im,
  input  logic                 cfg_mode,
  input  logic signed [DW-1:0] cfg_disp,
  input  logic signed [DW-1:0] cfg_step,
  input  logic [SHW-1:0]       cfg_shift
);
  localparam int CTR = NTAPS / 2;
  localparam logic signed [XW-1:0] RND = {{(XW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  eq_state_t          st;
  cplx_t [NTAPS-1:0]  dl, wt, wt_nx;
  cplx_t              x_in, y_c, y_q, e_c, e_q, g_c;
  logic               mode_q;
  smp_t               disp_q, step_q;
  logic signed [XW-1:0] ge_re, ge_im;

  function automatic cplx_t spike(input int k);
    cplx_t c;
    c.re = (k == CTR) ? ONE : '0;
    c.im = '0;
    return c;
  endfunction

  always_comb begin
    x_in.re = s_re >>> cfg_shift;
    x_in.im = s_im >>> cfg_shift;
    ge_re   = ext(step_q) * ext(e_q.re) + RND;
    ge_im   = ext(step_q) * ext(e_q.im) + RND;
    g_c.re  = sat(ge_re >>> FW);
    g_c.im  = sat(ge_im >>> FW);
  end

  eq_filter #(.NTAPS(NTAPS)) u_filt (.x(dl), .w(wt), .y(y_c));
  eq_err u_err (.per_axis(mode_q), .disp(disp_q), .y(y_q), .e(e_c));

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    eq_tap_upd u_upd (.g(g_c), .x(dl[k]), .w(wt[k]), .w_nx(wt_nx[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dl     <= '0;
      y_q    <= '0;
      e_q    <= '0;
      mode_q <= 1'b0;
      disp_q <= '0;
      step_q <= '0;
      for (int k = 0; k < NTAPS; k++) wt[k] <= spike(k);
    end else if (soft_clr) begin
      st <= ST_IDLE;
      dl <= '0;
      for (int k = 0; k < NTAPS; k++) wt[k] <= spike(k);
    end else begin
      case (st)
        ST_IDLE: if (s_valid) begin
          dl     <= {dl[NTAPS-2:0], x_in};
          mode_q <= cfg_mode;
          disp_q <= cfg_disp;
          step_q <= cfg_step;
          st     <= ST_FILT;
        end
        ST_FILT: begin
          y_q <= y_c;
          st  <= ST_ERR;
        end
        ST_ERR: begin
          e_q <= e_c;
          st  <= ST_UPD;
        end
        ST_UPD: begin
          wt <= wt_nx;
          st <= ST_OUT;
        end
        ST_OUT: if (m_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign s_ready = (st == ST_IDLE);
  assign m_valid = (st == ST_OUT);
  assign m_re    = y_q.re;
  assign m_im    = y_q.im;
endmodule

// File: rtl/eq_checker.sv
module eq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_clr,
  input logic        s_valid,
  input logic        s_ready,
  input logic        m_valid,
  input logic        m_ready,
  input logic [15:0] m_re,
  input logic [15:0] m_im
);
  logic [1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if (soft_clr) pend <= '0;
    else pend <= pend + 2'(s_valid && s_ready) - 2'(m_valid && m_ready);
  end

  // R1: no new transfer until the previous output has gone
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !soft_clr) |=> !s_ready);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  a_r1_one_out_per_in: assert property (@(posedge clk) disable iff (!rst_n)
    (pend <= 2'd1) && (m_valid -> pend == 2'd1));

  // R2: output held under back-pressure
  a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !soft_clr) |=> (m_valid && $stable(m_re) && $stable(m_im)));

  // R11: clear returns the handshake to idle
  a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (s_ready && !m_valid));
endmodule

bind modulus_equalizer eq_checker u_chk (.*);

// File: tb/modulus_equalizer_tb.sv
module modulus_equalizer_tb;
  localparam int NT = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_clr = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [15:0] s_re = '0, s_im = '0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic signed [15:0] m_re, m_im;
  logic cfg_mode = 1'b0;
  logic signed [15:0] cfg_disp = '0, cfg_step = '0;
  logic [1:0] cfg_shift = '0;

  int checks = 0;
  int fails = 0;
  int seed = 12345;

  longint mdr[NT], mdi[NT], mwr[NT], mwi[NT];

  always #4 clk = ~clk;

  modulus_equalizer u_dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_re(s_re), .s_im(s_im),
    .m_valid(m_valid), .m_ready(m_ready), .m_re(m_re), .m_im(m_im),
    .cfg_mode(cfg_mode), .cfg_disp(cfg_disp), .cfg_step(cfg_step), .cfg_shift(cfg_shift)
  );

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint fmul(input longint a, input longint b);
    return sat((a * b) >>> 13);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NT; k++) begin
      mdr[k] = 0; mdi[k] = 0; mwi[k] = 0;
      mwr[k] = (k == NT / 2) ? 8192 : 0;
    end
  endtask

  // R5 R6 R7 R8 R9: arithmetic model from the requirements
  task automatic model_step(input int xr, input int xi, output longint yr, output longint yi);
    longint ar, ai, p, d, er, ei, gr, gi, dr, di;
    for (int k = NT - 1; k > 0; k--) begin
      mdr[k] = mdr[k-1]; mdi[k] = mdi[k-1];
    end
    mdr[0] = longint'(xr) >>> cfg_shift;
    mdi[0] = longint'(xi) >>> cfg_shift;
    ar = 0; ai = 0;
    for (int k = 0; k < NT; k++) begin
      ar += mdr[k] * mwr[k] - mdi[k] * mwi[k];
      ai += mdr[k] * mwi[k] + mdi[k] * mwr[k];
    end
    yr = sat(ar >>> 13);
    yi = sat(ai >>> 13);
    if (cfg_mode == 1'b0) begin
      p  = sat((yr * yr + yi * yi) >>> 13);
      d  = sat(p - longint'(cfg_disp));
      er = fmul(yr, d);
      ei = fmul(yi, d);
    end else begin
      er = fmul(yr, sat(fmul(yr, yr) - longint'(cfg_disp)));
      ei = fmul(yi, sat(fmul(yi, yi) - longint'(cfg_disp)));
    end
    gr = sat((longint'(cfg_step) * er + 4096) >>> 13);
    gi = sat((longint'(cfg_step) * ei + 4096) >>> 13);
    for (int k = 0; k < NT; k++) begin
      dr = sat((gr * mdr[k] + gi * mdi[k]) >>> 13);
      di = sat((gi * mdr[k] - gr * mdi[k]) >>> 13);
      mwr[k] = sat(mwr[k] - dr);
      mwi[k] = sat(mwi[k] - di);
    end
  endtask

  task automatic xfer(input int xr, input int xi, input int stall, input bit flip, input string tag);
    longint yr, yi;
    logic signed [15:0] hr, hi;
    logic sv_mode;
    logic signed [15:0] sv_disp, sv_step;
    model_step(xr, xi, yr, yi);
    @(negedge clk);
    s_re = 16'(xr); s_im = 16'(xi); s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    sv_mode = cfg_mode; sv_disp = cfg_disp; sv_step = cfg_step;
    if (flip) begin
      cfg_mode = ~cfg_mode;
      cfg_disp = cfg_disp + 16'sd3000;
      cfg_step = cfg_step + 16'sd2000;
      chk("R1 s_ready low after transfer", s_ready, 0);
    end
    while (!m_valid) @(negedge clk);
    hr = m_re; hi = m_im;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R2 m_valid held", m_valid, 1);
      chk("R2 m_re stable", m_re, hr);
      chk("R1 s_ready low while output pending", s_ready, 0);
    end
    chk({tag, " re"}, m_re, yr);
    chk({tag, " im"}, m_im, yi);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    chk("R1 s_ready back after output taken", s_ready, 1);
    if (flip) begin
      cfg_mode = sv_mode; cfg_disp = sv_disp; cfg_step = sv_step;
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    model_clear();
  endtask

  function automatic int qam_lvl(input int sel, input int amp);
    case (sel & 3)
      0: return -3 * amp;
      1: return -amp;
      2: return amp;
      default: return 3 * amp;
    endcase
  endfunction

  task automatic next_seed();
    seed = seed * 1103515245 + 12345;
  endtask

  task automatic run_qam(input int n, input int amp, input string tag);
    int pr, pi, cr, ci;
    pr = 0; pi = 0;
    for (int i = 0; i < n; i++) begin
      next_seed();
      cr = qam_lvl(seed >>> 16, amp);
      next_seed();
      ci = qam_lvl(seed >>> 16, amp);
      xfer(cr + pr / 4, ci - pi / 4, 0, 1'b0, tag);
      pr = cr; pi = ci;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset s_ready", s_ready, 1);
    chk("R1 reset m_valid", m_valid, 0);

    // R3 R5 R6: step 0, each shift, ramp delayed by ten samples
    for (int sh = 0; sh < 4; sh++) begin
      cfg_shift = 2'(sh);
      cfg_step = '0;
      pulse_clear();
      for (int n = 0; n < 14; n++)
        xfer(n * 1537 - 9000, 4000 - n * 611, 0, 1'b0, "R3 R5 R6 passthrough");
    end

    // R7 R9: constant-modulus adaptation
    pulse_clear();
    cfg_shift = 2'd2; cfg_mode = 1'b0; cfg_disp = 16'sd2600; cfg_step = 16'sd82;
    run_qam(60, 2458, "R7 R9 constant-modulus");

    // R8 R9: per-axis adaptation
    pulse_clear();
    cfg_shift = 2'd1; cfg_mode = 1'b1; cfg_disp = 16'sd1700; cfg_step = 16'sd328;
    run_qam(60, 1800, "R8 R9 per-axis");

    // R4: full-scale values, then large step drives saturation
    pulse_clear();
    cfg_shift = 2'd0; cfg_mode = 1'b0; cfg_disp = '0; cfg_step = '0;
    for (int n = 0; n < 12; n++)
      xfer((n % 2) ? 32767 : -32768, (n % 2) ? -32768 : 32767, 0, 1'b0, "R4 full-scale passthrough");
    cfg_step = 16'sd8191;
    for (int n = 0; n < 10; n++)
      xfer((n % 3 == 0) ? 32767 : -20000, 30000 - n * 7000, 0, 1'b0, "R4 saturation");

    // R10: configuration flipped while a sample is in flight
    pulse_clear();
    cfg_shift = 2'd2; cfg_mode = 1'b1; cfg_disp = 16'sd1200; cfg_step = 16'sd200;
    for (int n = 0; n < 16; n++)
      xfer(n * 900 - 6000, 7000 - n * 500, 0, 1'b1, "R10 config latched");

    // R2: back-pressure
    xfer(5000, -5000, 6, 1'b0, "R2 stalled output");
    xfer(-3000, 2500, 3, 1'b0, "R2 stalled output");

    // R11: clear while an output is pending
    @(negedge clk);
    s_re = 16'sd4000; s_im = 16'sd4000; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    while (!m_valid) @(negedge clk);
    pulse_clear();
    chk("R11 pending output dropped", m_valid, 0);
    chk("R11 idle after clear", s_ready, 1);
    cfg_step = '0; cfg_shift = 2'd0;
    for (int n = 0; n < 12; n++)
      xfer(2000 + n * 100, -1000 - n * 50, 0, 1'b0, "R11 weights and delay line restored");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule